// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO

This block holds audio samples in flight between a processor bus and a serial audio port, for one stream direction at a time. In playback the processor writes samples into the data register and the serial side takes them in order. In capture the serial side deposits samples and the processor reads them back. The usable capacity depends on the configured size code and on the channel count. Software watches the fill level in whole frames and two sticky error flags. A level request tells it when to service the buffer.

A small controller with two named states handles the clear command. **RUN** is normal operation. **FLUSH** lasts exactly one cycle and empties the storage. Transition RUN→FLUSH happens on a control write with the clear bit set. Transition FLUSH→RUN happens unconditionally on the next clock. The register map is three word registers on a two-bit address: 0 is control, 1 is status, 2 is data.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset, the status register reads 0, the control register reads 0, the FIFO is empty and `fifo_req` is low.
- R2: Samples leave in the order they were accepted. In playback (`cap_mode`=0), processor writes to address 2 fill the FIFO and `ser_pop` drains it through `ser_rdata`. In capture (`cap_mode`=1), `ser_push` fills it and processor reads of address 2 drain it.
- R3: Capacity in words is ((BASE_WORDS << min(size_code, MAX_SIZE_CODE)) >> s) × ch. Here ch is `chan_cnt`, with 0 treated as 1 and values above MAX_CHAN treated as MAX_CHAN. The shift s is the smallest value with 2^s ≥ ch.
- R4: A push while the FIFO holds capacity words drops the word and sets the overrun flag, status bit 4.
- R5: A pop while the FIFO is empty returns zero on the popping side and sets the underrun flag, status bit 0.
- R6: Both flags are sticky. A status write clears each flag whose written bit is 0 and keeps each flag whose written bit is 1.
- R7: Status bits [16:8] hold floor(stored words / ch), saturated at 511.
- R8: A control write with bit 0 set enters FLUSH for one cycle. During that cycle control bit 0 reads 1. Afterwards it reads 0 and the fill level is 0. The error flags are kept, and pushes or pops in the FLUSH cycle are ignored.
- R9: Control bit 20 enables `fifo_req`. With half = capacity/2 (rounded down), the request is high when stored words ≤ half in playback and when stored words ≥ half in capture.
- R10: Only bits [23:0] of a data write are stored. `reg_rdata[31:24]` always reads 0.
- R11: With `sample16` set, bits [7:0] of every stored word are forced to 0, so a 16-bit sample sits in bits [23:8] on both sides.
- R12: In capture, processor data writes are ignored. In playback, processor data reads return 0 and remove nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data reads pop) |
| reg_addr | input | 2 | 0 control, 1 status, 2 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_rd` is high |
| cap_mode | input | 1 | 0 playback, 1 capture |
| sample16 | input | 1 | 16-bit sample alignment |
| size_code | input | 3 | Storage size code |
| chan_cnt | input | 4 | Channel count |
| ser_push | input | 1 | Serial side deposits a word (capture) |
| ser_wdata | input | 24 | Serial deposit data |
| ser_pop | input | 1 | Serial side takes a word (playback) |
| ser_rdata | output | 24 | Head word for the serial side, 0 when empty or in capture |
| fifo_req | output | 1 | Level service request |

## Verification
The bench builds the block with BASE_WORDS=16, MAX_SIZE_CODE=1 and MAX_CHAN=8. That gives 32 physical words. With it, every capacity case can be filled past the overflow point in a few dozen writes: 16, 12, 10 and 32 words. It also covers the clamping of the size code and the channel count, and the half-level threshold at 8 words for two channels in both directions. The 511-frame saturation of the level field cannot be reached at this size.

// File: rtl/asf_pkg.sv
package asf_pkg;
    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2
    } asf_addr_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } asf_state_e;

    localparam int WORD_W       = 24;
    localparam int LVL_W        = 9;
    localparam int LVL_LSB      = 8;
    localparam int CTRL_REQ_BIT = 20;
    localparam int CTRL_CLR_BIT = 0;
    localparam int STAT_OVR_BIT = 4;
    localparam int STAT_UND_BIT = 0;
endpackage

// File: rtl/asf_capacity.sv
module asf_capacity #(
    parameter int BASE_WORDS    = 256,
    parameter int MAX_SIZE_CODE = 1,
    parameter int MAX_CHAN      = 8,
    parameter int CW            = 10
) (
    input  logic [2:0]    size_code,
    input  logic [3:0]    chan_cnt,
    output logic [3:0]    chan_eff,
    output logic [CW-1:0] cap_words,
    output logic [CW-1:0] half_words
);
    localparam int SHW = $clog2(MAX_CHAN) + 1;

    logic [2:0]    code_eff;
    logic [CW-1:0] total;
    logic [CW-1:0] per_ch;
    logic [CW+3:0] prod;
    int            halvings;

    always_comb begin
        code_eff = (size_code > 3'(MAX_SIZE_CODE)) ? 3'(MAX_SIZE_CODE) : size_code;
        if (chan_cnt == 4'd0)
            chan_eff = 4'd1;
        else if (chan_cnt > 4'(MAX_CHAN))
            chan_eff = 4'(MAX_CHAN);
        else
            chan_eff = chan_cnt;
        total    = CW'(BASE_WORDS) << code_eff;
        halvings = 0;
        for (int i = 0; i < SHW; i++) begin
            if ((1 << i) < int'(chan_eff))
                halvings = i + 1;
        end
        per_ch     = total >> halvings;
        prod       = (CW+4)'(per_ch) * (CW+4)'(chan_eff);
        cap_words  = prod[CW-1:0];
        half_words = cap_words >> 1;
    end
endmodule

// File: rtl/asf_store.sv
module asf_store #(
    parameter int DEPTH = 512,
    parameter int AW    = 9,
    parameter int CW    = 10,
    parameter int WW    = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [WW-1:0] push_word,
    input  logic [CW-1:0] cap_words,
    output logic [WW-1:0] head_word,
    output logic [CW-1:0] fill,
    output logic          full,
    output logic          empty,
    output logic          ovf_evt,
    output logic          udf_evt
);
    logic [WW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign full    = (fill >= cap_words);
    assign empty   = (fill == '0);
    assign push_ok = push & ~full & ~flush;
    assign pop_ok  = pop & ~empty & ~flush;
    assign ovf_evt = push & full & ~flush;
    assign udf_evt = pop & empty & ~flush;
    assign head_word = empty ? '0 : mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push_ok) wptr <= wptr + AW'(1);
            if (pop_ok)  rptr <= rptr + AW'(1);
            unique case ({push_ok, pop_ok})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
    import asf_pkg::*;
#(
    parameter int BASE_WORDS    = 256,
    parameter int MAX_SIZE_CODE = 1,
    parameter int MAX_CHAN      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cap_mode,
    input  logic        sample16,
    input  logic [2:0]  size_code,
    input  logic [3:0]  chan_cnt,
    input  logic        ser_push,
    input  logic [23:0] ser_wdata,
    input  logic        ser_pop,
    output logic [23:0] ser_rdata,
    output logic        fifo_req
);
    localparam int DEPTH = BASE_WORDS << MAX_SIZE_CODE;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = AW + 1;

    asf_state_e        state, state_nxt;
    logic              flushing;
    logic              irq_en, ovr_flag, und_flag;
    logic              ctrl_wr, sts_wr, cpu_wr_data, cpu_rd_data;
    logic              push_req, pop_req;
    logic [WORD_W-1:0] push_raw, push_word, head_word;
    logic [CW-1:0]     fill, cap_words, half_words;
    logic [3:0]        chan_eff;
    logic              full, empty, ovf_evt, udf_evt;
    logic [CW-1:0]     frames;
    logic [CW+8:0]     frames_wide;
    logic [LVL_W-1:0]  level;
    logic              unused_hi;

    assign unused_hi   = ^reg_wdata[31:24];
    assign ctrl_wr     = reg_wr && (reg_addr == ADDR_CTRL);
    assign sts_wr      = reg_wr && (reg_addr == ADDR_STAT);
    assign cpu_wr_data = reg_wr && (reg_addr == ADDR_DATA);
    assign cpu_rd_data = reg_rd && (reg_addr == ADDR_DATA);

    assign push_req = cap_mode ? ser_push : cpu_wr_data;
    assign pop_req  = cap_mode ? cpu_rd_data : ser_pop;
    assign push_raw = cap_mode ? ser_wdata : reg_wdata[WORD_W-1:0];
    assign push_word = sample16 ? {push_raw[WORD_W-1:8], 8'h00} : push_raw;

    asf_capacity #(
        .BASE_WORDS(BASE_WORDS), .MAX_SIZE_CODE(MAX_SIZE_CODE),
        .MAX_CHAN(MAX_CHAN), .CW(CW)
    ) u_capacity (
        .size_code(size_code), .chan_cnt(chan_cnt), .chan_eff(chan_eff),
        .cap_words(cap_words), .half_words(half_words)
    );

    asf_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .WW(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flushing), .push(push_req),
        .pop(pop_req), .push_word(push_word), .cap_words(cap_words),
        .head_word(head_word), .fill(fill), .full(full), .empty(empty),
        .ovf_evt(ovf_evt), .udf_evt(udf_evt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:   if (ctrl_wr && reg_wdata[CTRL_CLR_BIT]) state_nxt = ST_FLUSH;
            ST_FLUSH: state_nxt = ST_RUN;
        endcase
    end

    // State outputs
    always_comb begin
        unique case (state)
            ST_RUN:   flushing = 1'b0;
            ST_FLUSH: flushing = 1'b1;
        endcase
    end

    // Control and sticky error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= 1'b0;
            ovr_flag <= 1'b0;
            und_flag <= 1'b0;
        end else begin
            if (ctrl_wr) irq_en <= reg_wdata[CTRL_REQ_BIT];
            ovr_flag <= (ovr_flag & (~sts_wr | reg_wdata[STAT_OVR_BIT])) | ovf_evt;
            und_flag <= (und_flag & (~sts_wr | reg_wdata[STAT_UND_BIT])) | udf_evt;
        end
    end

    assign frames      = fill / CW'(chan_eff);
    assign frames_wide = (CW+9)'(frames);
    assign level       = (frames_wide > (CW+9)'(511)) ? 9'h1FF : frames_wide[LVL_W-1:0];

    assign fifo_req  = irq_en & (cap_mode ? (fill >= half_words) : (fill <= half_words));
    assign ser_rdata = cap_mode ? '0 : head_word;

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                ADDR_CTRL: begin
                    reg_rdata[CTRL_REQ_BIT] = irq_en;
                    reg_rdata[CTRL_CLR_BIT] = flushing;
                end
                ADDR_STAT: begin
                    reg_rdata[LVL_LSB +: LVL_W] = level;
                    reg_rdata[STAT_OVR_BIT]     = ovr_flag;
                    reg_rdata[STAT_UND_BIT]     = und_flag;
                end
                ADDR_DATA: reg_rdata[WORD_W-1:0] = cap_mode ? head_word : '0;
                default:   reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/asf_checker.sv
module asf_checker #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_req,
    input logic          full,
    input logic          empty,
    input logic          flushing,
    input logic [CW-1:0] fill,
    input logic          und_flag,
    input logic          ovr_flag,
    input logic          sts_wr,
    input logic          irq_en,
    input logic          fifo_req,
    input logic          cap_mode,
    input logic          cpu_rd_data,
    input logic [31:0]   reg_rdata
);
    a_r4_no_growth_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !flushing) |=> (fill <= $past(fill)));

    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && cpu_rd_data && empty) |-> (reg_rdata == 32'd0));

    a_r6_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (und_flag && !sts_wr) |=> und_flag);

    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !sts_wr) |=> ovr_flag);

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |=> (fill == '0));

    a_r8_flush_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |=> !flushing);

    a_r9_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !fifo_req);

    a_r10_top_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:24] == 8'd0);
endmodule

bind audio_sample_fifo asf_checker #(.CW(CW)) u_asf_checker (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .full(full), .empty(empty),
    .flushing(flushing), .fill(fill), .und_flag(und_flag), .ovr_flag(ovr_flag),
    .sts_wr(sts_wr), .irq_en(irq_en), .fifo_req(fifo_req), .cap_mode(cap_mode),
    .cpu_rd_data(cpu_rd_data), .reg_rdata(reg_rdata)
);

// File: tb/test_audio_sample_fifo.sv
module test_audio_sample_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int BASE  = 16;
    localparam int MAXC  = 1;
    localparam int MAXCH = 8;
    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        cap_mode = 1'b0, sample16 = 1'b0;
    logic [2:0]  size_code = '0;
    logic [3:0]  chan_cnt = '0;
    logic        ser_push = 1'b0, ser_pop = 1'b0;
    logic [23:0] ser_wdata = '0, ser_rdata;
    logic        fifo_req;

    audio_sample_fifo #(.BASE_WORDS(BASE), .MAX_SIZE_CODE(MAXC), .MAX_CHAN(MAXCH))
    i_audio_sample_fifo (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cap_mode(cap_mode), .sample16(sample16), .size_code(size_code),
        .chan_cnt(chan_cnt), .ser_push(ser_push), .ser_wdata(ser_wdata),
        .ser_pop(ser_pop), .ser_rdata(ser_rdata), .fifo_req(fifo_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          checks = 0, fails = 0;
    logic [23:0] q[$];
    bit          m_ovr = 0, m_und = 0, m_s16 = 0, m_capm = 0, done = 0;
    int          m_cap = 16, m_ch = 1;

    function automatic int calc_cap(int code, int ch);
        int c = (code > MAXC) ? MAXC : code;
        int n = (ch < 1) ? 1 : ((ch > MAXCH) ? MAXCH : ch);
        int s = 0;
        while ((1 << s) < n) s++;
        return ((BASE << c) >> s) * n;
    endfunction

    function automatic logic [31:0] exp_status();
        int lv = q.size() / m_ch;
        if (lv > 511) lv = 511;
        return (32'(lv) << 8) | (32'(m_ovr) << 4) | 32'(m_und);
    endfunction

    function automatic logic [23:0] mask(logic [31:0] w);
        logic [23:0] v = w[23:0];
        if (m_s16) v[7:0] = 8'h00;
        return v;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #2 v = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic check_status(string tag);
        logic [31:0] v;
        rd_reg(A_STAT, v);
        chk(tag, v, exp_status());
    endtask

    task automatic configure(int code, int ch, bit capm, bit s16, bit irq);
        size_code = 3'(code); chan_cnt = 4'(ch); cap_mode = capm; sample16 = s16;
        m_capm = capm; m_s16 = s16;
        m_cap = calc_cap(code, ch);
        m_ch = (ch < 1) ? 1 : ((ch > MAXCH) ? MAXCH : ch);
        wr_reg(A_CTRL, (32'(irq) << 20) | 32'd1);
        q.delete();
        tick();
    endtask

    task automatic clear_flags();
        wr_reg(A_STAT, 32'd0);
        m_ovr = 0; m_und = 0;
    endtask

    // Driver: playback push from the processor side
    task automatic cpu_push(logic [31:0] w);
        if (!m_capm) begin
            if (q.size() < m_cap) q.push_back(mask(w));
            else m_ovr = 1;
        end
        wr_reg(A_DATA, w);
    endtask

    // Driver: serial side takes one word; the monitor compares
    task automatic ser_take();
        ser_pop = 1'b1;
        tick();
        ser_pop = 1'b0;
    endtask

    // Driver: serial side deposits one word in capture
    task automatic ser_give(logic [23:0] w);
        if (q.size() < m_cap) q.push_back(mask({8'h00, w}));
        else m_ovr = 1;
        ser_push = 1'b1; ser_wdata = w;
        tick();
        ser_push = 1'b0;
    endtask

    // Capture read by the processor, compared against the scoreboard
    task automatic cpu_take(string tag, output logic [31:0] got);
        logic [31:0] exp;
        reg_rd = 1'b1; reg_addr = A_DATA;
        #2 got = reg_rdata;
        if (q.size() > 0) exp = {8'h00, q.pop_front()};
        else begin exp = 0; m_und = 1; end
        chk(tag, got, exp);
        tick();
        reg_rd = 1'b0;
    endtask

    // Monitor: playback words leaving on the serial side
    always @(negedge clk) begin
        if (ser_pop && !m_capm) begin
            if (q.size() > 0) chk("R2 serial order/data", {8'h00, ser_rdata}, {8'h00, q.pop_front()});
            else begin
                chk("R5 serial underrun data", {8'h00, ser_rdata}, 32'd0);
                m_und = 1;
            end
        end
    end

    task automatic fill_probe(int code, int ch);
        configure(code, ch, 0, 0, 0);
        clear_flags();
        for (int i = 0; i < m_cap; i++) cpu_push(32'h0A0000 + 32'(i));
        check_status("R3 filled to capacity, no overrun");
        cpu_push(32'h0BBBBB);
        check_status("R4 one past capacity sets overrun");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check_status("R1 status after reset");
        rd_reg(A_CTRL, v); chk("R1 control after reset", v, 32'd0);
        chk("R1 request after reset", {31'd0, fifo_req}, 32'd0);

        // R2, R7: two channels, 16 words
        configure(0, 2, 0, 0, 0);
        for (int i = 0; i < 5; i++) cpu_push(32'h100001 + 32'(i));
        check_status("R7 five words two channels -> 2 frames");
        for (int i = 0; i < 5; i++) ser_take();
        check_status("R2 drained");

        // R3, R4: three channels, 12 words; dropped words never appear
        configure(0, 3, 0, 0, 0);
        for (int i = 0; i < 14; i++) cpu_push(32'h200000 + 32'(i));
        check_status("R4 overrun at 3 channels, 4 frames");
        for (int i = 0; i < 12; i++) ser_take();
        check_status("R4 overrun sticky after drain");

        // R3 capacity under several configurations
        fill_probe(0, 5);
        fill_probe(1, 1);
        fill_probe(5, 8);
        fill_probe(0, 0);

        // R5 underrun on both sides
        configure(0, 2, 0, 0, 0);
        clear_flags();
        ser_take();
        check_status("R5 serial pop on empty");
        configure(0, 1, 1, 0, 0);
        clear_flags();
        cpu_take("R5 processor read on empty", v);
        check_status("R5 processor underrun flag");

        // R6 sticky and per-bit clear
        for (int i = 0; i < 17; i++) ser_give(24'h300000 + 24'(i));
        check_status("R6 both flags held");
        wr_reg(A_STAT, 32'h10); m_und = 0;
        check_status("R6 write keeps overrun clears underrun");
        wr_reg(A_STAT, 32'h0); m_ovr = 0;
        check_status("R6 write zero clears both");
        for (int i = 0; i < 16; i++) cpu_take("R2 capture order", v);
        check_status("R2 capture drained");

        // R8 clear command
        configure(0, 2, 0, 0, 0);
        clear_flags();
        ser_take();
        for (int i = 0; i < 4; i++) cpu_push(32'h400000 + 32'(i));
        wr_reg(A_CTRL, 32'd1);
        rd_reg(A_CTRL, v); chk("R8 clear bit visible during flush", v, 32'd1);
        rd_reg(A_CTRL, v); chk("R8 clear bit self-cleared", v, 32'd0);
        q.delete();
        check_status("R8 empty after clear, flags kept");
        wr_reg(A_CTRL, 32'd1);
        wr_reg(A_DATA, 32'h777777);
        check_status("R8 push during flush ignored");

        // R9 level request
        configure(0, 2, 0, 0, 1);
        chk("R9 playback empty requests", {31'd0, fifo_req}, 32'd1);
        for (int i = 0; i < 8; i++) cpu_push(32'h500000 + 32'(i));
        chk("R9 playback at half requests", {31'd0, fifo_req}, 32'd1);
        cpu_push(32'h500008);
        chk("R9 playback above half quiet", {31'd0, fifo_req}, 32'd0);
        configure(0, 2, 1, 0, 1);
        chk("R9 capture empty quiet", {31'd0, fifo_req}, 32'd0);
        for (int i = 0; i < 7; i++) ser_give(24'h600000 + 24'(i));
        chk("R9 capture below half quiet", {31'd0, fifo_req}, 32'd0);
        ser_give(24'h600007);
        chk("R9 capture at half requests", {31'd0, fifo_req}, 32'd1);
        configure(0, 2, 1, 0, 0);
        for (int i = 0; i < 10; i++) ser_give(24'h610000 + 24'(i));
        chk("R9 disabled request stays low", {31'd0, fifo_req}, 32'd0);

        // R10, R11 data width and alignment
        configure(0, 2, 0, 0, 0);
        clear_flags();
        cpu_push(32'hAB123456);
        ser_take();
        configure(0, 2, 0, 1, 0);
        cpu_push(32'h00ABCD99);
        chk("R11 playback stored word aligned", {8'h00, q[0]}, 32'h00ABCD00);
        ser_take();
        configure(0, 2, 1, 1, 0);
        ser_give(24'h5A5A5A);
        cpu_take("R11 capture low byte zeroed", v);
        chk("R11 sample after shift by 8", v >> 8, 32'h5A5A);
        chk("R10 upper byte of read zero", {24'd0, v[31:24]}, 32'd0);

        // R12 wrong-direction data accesses
        configure(0, 2, 1, 0, 0);
        wr_reg(A_DATA, 32'h111111);
        check_status("R12 capture ignores processor write");
        configure(0, 2, 0, 0, 0);
        cpu_push(32'h700001);
        cpu_push(32'h700002);
        rd_reg(A_DATA, v); chk("R12 playback data read returns zero", v, 32'd0);
        check_status("R12 playback read removed nothing");
        ser_take();
        ser_take();

        tick();
        finish_run();
    end
endmodule